// File: doc/BRIEF.md
# Receive packet status queue

This block keeps one status record per received frame for a receive buffer that can hold several frames at once. The receive MAC signals the start of a frame, one strobe per stored byte, and an end-of-frame strobe with a 4-bit completion code. The block opens a record at each frame start. It counts the bytes into that record and seals it with a classified error type at the end of the frame.

The host always sees a 16-bit status word for the oldest frame. Each host data read takes two bytes from that frame, or one byte when only one is left. A command with opcode 0x08 drops the oldest frame, and opcode 0x05 clears the whole receive side. The queue holds at most `DEPTH` frames. A frame that arrives while the queue is full is refused and flagged as a status overrun. A host read with no data left raises a sticky receive underrun and pulses a failure event. The frame bytes themselves are not stored here; each frame is held only as a count of bytes not yet read.

Top module: `rx_stat_queue`

## Requirements
- R1: After `rst_n` is released, `stat_word` is 0x8000 (bit 15 set: empty) and `frame_cnt`, `receiving`, `stat_ovr` and `rx_underrun` are all 0.
- R2: For a completed oldest frame, `stat_word` bit 15 is 0, bits 14..11 hold the error type and bits 10..0 hold the bytes not yet read.
- R3: The end-of-frame code is reported unchanged in bits 14..11 when it is 1000 (overrun), 1011 (runt), 1100 (alignment), 1101 (CRC), 1001 (oversize) or 0010 (dribble). Any other code is reported as 0000, meaning no error.
- R4: A frame longer than `MAX_BYTES` bytes whose code maps to 0000 is reported with type 1001. A frame of exactly `MAX_BYTES` bytes, or a frame that carries one of the listed error codes, keeps its own type.
- R5: While the oldest frame is still arriving, `stat_word` shows bit 15 set, bits 14..11 at 0000 and the running byte count. `receiving` is 1 from the clock edge that takes a frame start until the edge that takes its end.
- R6: A frame start that arrives while `DEPTH` frames are queued is refused. `stat_ovr` goes to 1, `frame_cnt` does not change, and the refused frame's bytes and end strobe have no effect. `stat_ovr` returns to 0 at the edge where a discard removes a frame.
- R7: Each host read takes 2 bytes from the oldest frame's count, or 1 byte when exactly one is left.
- R8: A host read with the queue empty, or with the oldest frame's count at 0, sets `rx_underrun` and pulses `fail_evt` high for one cycle. `rx_underrun` stays at 1 until an RX reset (opcode 0x05) or `rst_n`.
- R9: Opcode 0x08 removes the oldest frame, and the next frame's status then appears. If that frame is still arriving, reception of it stops. On an empty queue the command has no effect. Opcodes other than 0x05 and 0x08 are ignored.
- R10: `rx_done_evt` is high for exactly the one cycle after the clock edge that takes the end strobe of an accepted frame.
- R11: Opcode 0x05 empties the queue and clears `receiving`, `stat_ovr` and `rx_underrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| mac_sof | input | 1 | Frame start from the receive MAC |
| mac_byte | input | 1 | One byte of the current frame was stored |
| mac_eof | input | 1 | Frame end from the receive MAC |
| mac_code | input | 4 | Completion code, sampled with `mac_eof` |
| host_rd | input | 1 | Host data read of two bytes |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 5 | Command opcode |
| stat_word | output | 16 | Status of the oldest frame |
| frame_cnt | output | PW+1 | Number of queued frames |
| receiving | output | 1 | A frame is being written |
| stat_ovr | output | 1 | Status overrun: a frame was refused because the queue was full |
| rx_underrun | output | 1 | Sticky flag: the host read past the received data |
| fail_evt | output | 1 | One-cycle adapter-failure event |
| rx_done_evt | output | 1 | One-cycle frame-complete event |

## Verification
The bench builds the block with `DEPTH` = 4 and `MAX_BYTES` = 20. The small depth lets a run of short frames fill the queue, so the refused fifth frame and the clearing of the overrun flag on discard are reached within a few dozen cycles. The small byte limit makes a 21-byte frame an oversize case, so the forced type 1001 and the boundary at exactly 20 bytes can both be checked without long frames.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
   localparam logic [4:0] OP_RX_RESET = 5'h05;
   localparam logic [4:0] OP_DISCARD  = 5'h08;

   localparam logic [3:0] ERR_NONE     = 4'b0000;
   localparam logic [3:0] ERR_DRIBBLE  = 4'b0010;
   localparam logic [3:0] ERR_OVERRUN  = 4'b1000;
   localparam logic [3:0] ERR_OVERSIZE = 4'b1001;
   localparam logic [3:0] ERR_RUNT     = 4'b1011;
   localparam logic [3:0] ERR_ALIGN    = 4'b1100;
   localparam logic [3:0] ERR_CRC      = 4'b1101;

   // Keep a recognised error code, fold everything else to "no error".
   function automatic logic [3:0] rsq_classify(input logic [3:0] c);
      case (c)
         ERR_DRIBBLE, ERR_OVERRUN, ERR_OVERSIZE,
         ERR_RUNT, ERR_ALIGN, ERR_CRC: return c;
         default:                      return ERR_NONE;
      endcase
   endfunction
endpackage

// File: rtl/rsq_ring.sv
module rsq_ring #(
   parameter int DEPTH = 8,
   parameter int CW    = 11,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          pop,
   input  logic          inc,
   input  logic [PW-1:0] inc_idx,
   input  logic [1:0]    dec_amt,
   input  logic          close,
   input  logic [3:0]    close_code,
   output logic [PW-1:0] tail_idx,
   output logic [PW:0]   occ,
   output logic [CW-1:0] head_cnt,
   output logic          head_done,
   output logic [3:0]    head_code
);
   logic [PW-1:0] head_q, tail_q;
   logic [PW:0]   occ_q;
   logic [CW-1:0] cnt_all  [DEPTH];
   logic          done_all [DEPTH];
   logic [3:0]    code_all [DEPTH];

   function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [CW-1:0] cnt_q;
      logic          done_q;
      logic [3:0]    code_q;
      logic          here_inc, here_wr;
      logic [CW-1:0] inc_v, dec_v;

      assign here_wr  = (inc_idx == PW'(i));
      assign here_inc = inc && here_wr && (cnt_q != '1);
      assign inc_v    = CW'(here_inc);
      assign dec_v    = (head_q == PW'(i)) ? CW'(dec_amt) : '0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
            code_q <= '0;
         end else if (clr || (push && tail_q == PW'(i))) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
            code_q <= '0;
         end else begin
            cnt_q <= cnt_q + inc_v - dec_v;
            if (close && here_wr) begin
               done_q <= 1'b1;
               code_q <= close_code;
            end
         end
      end

      assign cnt_all[i]  = cnt_q;
      assign done_all[i] = done_q;
      assign code_all[i] = code_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         occ_q  <= '0;
      end else if (clr) begin
         head_q <= '0;
         tail_q <= '0;
         occ_q  <= '0;
      end else begin
         if (push) tail_q <= nxt(tail_q);
         if (pop)  head_q <= nxt(head_q);
         occ_q <= occ_q + (PW+1)'(push) - (PW+1)'(pop);
      end
   end

   assign tail_idx  = tail_q;
   assign occ       = occ_q;
   assign head_cnt  = cnt_all[head_q];
   assign head_done = done_all[head_q];
   assign head_code = code_all[head_q];

   AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !clr) |-> (occ_q != '0)); // R9
   AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !clr) |-> (occ_q < (PW+1)'(DEPTH))); // R6
endmodule

// File: rtl/rsq_fmt.sv
module rsq_fmt #(
   parameter int CW = 11
) (
   input  logic          empty,
   input  logic          done,
   input  logic [3:0]    code,
   input  logic [CW-1:0] cnt,
   output logic [15:0]   word
);
   if (CW + 5 != 16) begin : g_bad_width
      $error("rsq_fmt: count field must fill bits 10..0");
   end

   always_comb begin
      if (empty) word = {1'b1, 15'b0};
      else       word = {~done, (done ? code : 4'b0000), cnt};
   end
endmodule

// File: rtl/rx_stat_queue.sv
module rx_stat_queue #(
   parameter int DEPTH     = 8,
   parameter int MAX_BYTES = 1514,
   localparam int PW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW       = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mac_sof,
   input  logic          mac_byte,
   input  logic          mac_eof,
   input  logic [3:0]    mac_code,
   input  logic          host_rd,
   input  logic          cmd_valid,
   input  logic [4:0]    cmd_op,
   output logic [15:0]   stat_word,
   output logic [PW:0]   frame_cnt,
   output logic          receiving,
   output logic          stat_ovr,
   output logic          rx_underrun,
   output logic          fail_evt,
   output logic          rx_done_evt
);
   import rsq_pkg::*;

   if (DEPTH < 2) begin : g_bad_depth
      $error("rx_stat_queue: DEPTH must be at least 2");
   end
   if (MAX_BYTES < 1 || MAX_BYTES >= (1 << CW) - 1) begin : g_bad_max
      $error("rx_stat_queue: MAX_BYTES must fit the count field");
   end

   logic          recv_q, ovr_q, und_q, fail_q, done_q;
   logic [PW-1:0] cur_q, tail_idx;
   logic [CW-1:0] len_q, head_cnt;
   logic [PW:0]   occ;
   logic          head_done;
   logic [3:0]    head_code, cls, close_code;
   logic          rx_rst, empty, full, disc, disc_cur, live;
   logic          sof_ok, sof_drop, inc, close, bad_rd;
   logic [1:0]    dec_amt;
   logic [CW:0]   len_now;

   assign rx_rst   = cmd_valid && (cmd_op == OP_RX_RESET);
   assign empty    = (occ == '0);
   assign full     = (occ == (PW+1)'(DEPTH));
   assign disc     = cmd_valid && (cmd_op == OP_DISCARD) && !empty && !rx_rst;
   // The frame being written is the newest; it is the oldest only when alone.
   assign disc_cur = disc && recv_q && (occ == (PW+1)'(1));
   assign live     = recv_q && !disc_cur && !rx_rst;
   assign sof_ok   = mac_sof && !recv_q && !full && !rx_rst;
   assign sof_drop = mac_sof && !recv_q && full && !rx_rst;
   assign inc      = mac_byte && live;
   assign close    = mac_eof && live;
   assign bad_rd   = host_rd && (empty || head_cnt == '0) && !rx_rst;

   always_comb begin
      dec_amt = 2'd0;
      if (host_rd && !empty && !rx_rst)
         dec_amt = (head_cnt >= CW'(2)) ? 2'd2 : head_cnt[1:0];
   end

   assign len_now = {1'b0, len_q} + (CW+1)'(inc);
   assign cls     = rsq_classify(mac_code);
   assign close_code = ((cls == ERR_NONE) && (len_now > (CW+1)'(MAX_BYTES)))
                       ? ERR_OVERSIZE : cls;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         recv_q <= 1'b0;
         cur_q  <= '0;
         len_q  <= '0;
         ovr_q  <= 1'b0;
         und_q  <= 1'b0;
         fail_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         fail_q <= bad_rd;
         done_q <= close;
         if (rx_rst) begin
            recv_q <= 1'b0;
            ovr_q  <= 1'b0;
            und_q  <= 1'b0;
         end else begin
            if (sof_ok) begin
               recv_q <= 1'b1;
               cur_q  <= tail_idx;
               len_q  <= '0;
            end else if (close || disc_cur) begin
               recv_q <= 1'b0;
            end else if (inc && len_q != '1) begin
               len_q <= len_q + 1'b1;
            end
            if (disc)          ovr_q <= 1'b0;
            else if (sof_drop) ovr_q <= 1'b1;
            if (bad_rd) und_q <= 1'b1;
         end
      end
   end

   rsq_ring #(.DEPTH(DEPTH), .CW(CW)) u_ring (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (rx_rst),
      .push       (sof_ok),
      .pop        (disc),
      .inc        (inc),
      .inc_idx    (cur_q),
      .dec_amt    (dec_amt),
      .close      (close),
      .close_code (close_code),
      .tail_idx   (tail_idx),
      .occ        (occ),
      .head_cnt   (head_cnt),
      .head_done  (head_done),
      .head_code  (head_code)
   );

   rsq_fmt #(.CW(CW)) u_fmt (
      .empty (empty),
      .done  (head_done),
      .code  (head_code),
      .cnt   (head_cnt),
      .word  (stat_word)
   );

   assign frame_cnt   = occ;
   assign receiving   = recv_q;
   assign stat_ovr    = ovr_q;
   assign rx_underrun = und_q;
   assign fail_evt    = fail_q;
   assign rx_done_evt = done_q;

   AST_OVR_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_q |-> full); // R6
   AST_RECV_HAS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      recv_q |-> !empty); // R5
   AST_UND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (und_q && !rx_rst) |=> und_q); // R8
   AST_FAIL_WITH_UND: assert property (@(posedge clk) disable iff (!rst_n)
      fail_q |-> und_q); // R8
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R10
endmodule

// File: tb/sim_rx_stat_queue.sv
module sim_rx_stat_queue;
   localparam int CLK_P = 10;
   localparam int DEPTH = 4;
   localparam int MAXB  = 20;
   localparam int PW    = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mac_sof = 1'b0, mac_byte = 1'b0, mac_eof = 1'b0;
   logic [3:0]    mac_code = 4'h0;
   logic          host_rd = 1'b0, cmd_valid = 1'b0;
   logic [4:0]    cmd_op = 5'h0;
   logic [15:0]   stat_word;
   logic [PW:0]   frame_cnt;
   logic          receiving, stat_ovr, rx_underrun, fail_evt, rx_done_evt;

   rx_stat_queue #(.DEPTH(DEPTH), .MAX_BYTES(MAXB)) u0 (
      .clk(clk), .rst_n(rst_n), .mac_sof(mac_sof), .mac_byte(mac_byte),
      .mac_eof(mac_eof), .mac_code(mac_code), .host_rd(host_rd),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .stat_word(stat_word),
      .frame_cnt(frame_cnt), .receiving(receiving), .stat_ovr(stat_ovr),
      .rx_underrun(rx_underrun), .fail_evt(fail_evt), .rx_done_evt(rx_done_evt)
   );

   always #(CLK_P/2) clk = ~clk;

   int          n_chk = 0, n_err = 0;
   logic [15:0] exp_q[$];
   string       tag_q[$];
   logic [15:0] sb_e;
   string       sb_t;

   // Monitor: compares each queued expectation with the status word.
   always @(negedge clk) begin
      while (exp_q.size() > 0) begin
         sb_e = exp_q.pop_front();
         sb_t = tag_q.pop_front();
         n_chk++;
         if (stat_word !== sb_e) begin
            n_err++;
            $display("FAIL %s stat_word act=%h exp=%h", sb_t, stat_word, sb_e);
         end
      end
   end

   task automatic push_word(input logic [15:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
   endtask

   task automatic chk(input string t, input logic [31:0] a, input logic [31:0] e);
      n_chk++;
      if (a !== e) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h", t, a, e);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic sof();
      mac_sof = 1'b1; tick(); mac_sof = 1'b0;
   endtask

   task automatic bytes(input int n);
      for (int i = 0; i < n; i++) begin
         mac_byte = 1'b1; tick();
      end
      mac_byte = 1'b0;
   endtask

   task automatic eof(input logic [3:0] c);
      mac_eof = 1'b1; mac_code = c; tick(); mac_eof = 1'b0;
   endtask

   task automatic frame(input int n, input logic [3:0] c);
      sof(); bytes(n); eof(c);
   endtask

   task automatic rd();
      host_rd = 1'b1; tick(); host_rd = 1'b0;
   endtask

   task automatic cmd(input logic [4:0] op);
      cmd_valid = 1'b1; cmd_op = op; tick(); cmd_valid = 1'b0;
   endtask

   function automatic logic [3:0] exp_type(input logic [3:0] c);
      if (c == 4'b1000 || c == 4'b1011 || c == 4'b1100 ||
          c == 4'b1101 || c == 4'b1001 || c == 4'b0010) return c;
      return 4'b0000;
   endfunction

   localparam logic [4:0] DISCARD = 5'h08;
   localparam logic [4:0] RXRST   = 5'h05;

   initial begin
      #(CLK_P * 100000);
      n_err++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [3:0] codes [8];
      codes = '{4'h8, 4'hB, 4'hC, 4'hD, 4'h9, 4'h2, 4'h3, 4'hF};
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();

      // R1 reset state
      push_word(16'h8000, "R1");
      chk("R1 frame_cnt", 32'(frame_cnt), 0);
      chk("R1 receiving", 32'(receiving), 0);
      chk("R1 stat_ovr", 32'(stat_ovr), 0);
      chk("R1 rx_underrun", 32'(rx_underrun), 0);

      // R5 frame in progress, R10 completion pulse, R2 completed word
      sof();
      chk("R5 receiving after sof", 32'(receiving), 1);
      bytes(3);
      push_word(16'h8003, "R5 running count");
      bytes(2);
      eof(4'h0);
      chk("R10 rx_done_evt high", 32'(rx_done_evt), 1);
      chk("R5 receiving after eof", 32'(receiving), 0);
      push_word(16'h0005, "R2 completed word");
      tick();
      chk("R10 rx_done_evt low", 32'(rx_done_evt), 0);

      // R7 reads take two bytes, one when one is left
      rd(); push_word(16'h0003, "R7 first read");
      rd(); push_word(16'h0001, "R7 second read");
      rd(); push_word(16'h0000, "R7 last byte");
      chk("R8 no underrun yet", 32'(rx_underrun), 0);

      // R8 over-read
      rd();
      chk("R8 fail_evt pulse", 32'(fail_evt), 1);
      chk("R8 underrun set", 32'(rx_underrun), 1);
      tick();
      chk("R8 fail_evt one cycle", 32'(fail_evt), 0);
      cmd(DISCARD);
      push_word(16'h8000, "R9 discard to empty");
      chk("R8 underrun sticky over discard", 32'(rx_underrun), 1);
      cmd(RXRST);
      chk("R8 RX reset clears underrun", 32'(rx_underrun), 0);
      rd();
      chk("R8 read on empty queue", 32'(rx_underrun), 1);
      cmd(RXRST);

      // R3 error type mapping
      for (int k = 0; k < 8; k++) begin
         frame(2, codes[k]);
         push_word({1'b0, exp_type(codes[k]), 11'd2}, "R3 error type");
         cmd(DISCARD);
      end

      // R4 oversize
      frame(MAXB + 1, 4'h0);
      push_word({1'b0, 4'b1001, 11'(MAXB + 1)}, "R4 oversize forced");
      cmd(DISCARD);
      frame(MAXB, 4'h0);
      push_word({1'b0, 4'b0000, 11'(MAXB)}, "R4 at limit");
      cmd(DISCARD);
      frame(MAXB + 1, 4'hD);
      push_word({1'b0, 4'b1101, 11'(MAXB + 1)}, "R4 own code kept");
      cmd(DISCARD);

      // R6 queue limit and status overrun
      for (int k = 1; k <= DEPTH; k++) frame(k, 4'h0);
      chk("R6 queue full", 32'(frame_cnt), DEPTH);
      sof();
      chk("R6 stat_ovr set", 32'(stat_ovr), 1);
      chk("R6 refused frame not receiving", 32'(receiving), 0);
      bytes(3);
      eof(4'h0);
      chk("R6 no completion for refused frame", 32'(rx_done_evt), 0);
      chk("R6 frame_cnt unchanged", 32'(frame_cnt), DEPTH);
      push_word(16'h0001, "R6 head unchanged");
      cmd(5'h09);
      push_word(16'h0001, "R9 other opcode ignored");
      chk("R9 other opcode frame_cnt", 32'(frame_cnt), DEPTH);
      chk("R6 stat_ovr held", 32'(stat_ovr), 1);
      cmd(DISCARD);
      chk("R6 stat_ovr cleared", 32'(stat_ovr), 0);
      push_word(16'h0002, "R9 next frame shown");
      chk("R9 frame_cnt after discard", 32'(frame_cnt), DEPTH - 1);

      // R11 RX reset empties the queue
      cmd(RXRST);
      chk("R11 frame_cnt", 32'(frame_cnt), 0);
      push_word(16'h8000, "R11 empty word");

      // R9 discard on empty has no effect
      cmd(DISCARD);
      push_word(16'h8000, "R9 discard on empty");
      chk("R9 empty frame_cnt", 32'(frame_cnt), 0);

      // R9 discard of a frame still arriving
      sof();
      bytes(2);
      cmd(DISCARD);
      chk("R9 reception stopped", 32'(receiving), 0);
      bytes(1);
      eof(4'h0);
      chk("R9 no completion after discard", 32'(rx_done_evt), 0);
      chk("R9 nothing queued", 32'(frame_cnt), 0);
      push_word(16'h8000, "R9 still empty");

      tick();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule